// File: doc/BRIEF.md
# Exception Entry Sequencer

This block runs the entry sequence of a processor core when an exception is taken. The core has two modes: a compatible 8-bit emulation mode and a 16-bit native mode. Three hardware sources can raise a request: reset, NMI and IRQ. Software can raise one with a BRK or COP opcode. When the sequencer is idle, it picks the request with the highest priority and latches the core's program counter, program bank, status and stack pointer. It then drives one bus cycle per step: an optional signature-byte read, the stack pushes and two vector reads. A final cycle hands the new register values back to the core.

Emulation mode changes three things:
- The frame is three bytes and the program bank is not pushed.
- The stack is confined to page one.
- BRK shares the IRQ vector and is marked by the break bit in the stacked status.

In native mode the frame is four bytes, BRK has its own vector and the program bank is cleared on entry. Opcode decode, return from interrupt and the ALU belong to the surrounding core.

Top module: `exc_entry_seq`

## Requirements
- R1: The sequencer accepts requests only when idle. When several are present at the same time, it services them in this order: reset, then NMI, then IRQ, then BRK, then COP.
- R2: The hardware vectors are 0xFFFC for reset, 0xFFFA for NMI and 0xFFFE for IRQ.
- R3: BRK uses vector 0xFFFE in emulation mode and 0xFFF6 in native mode. COP uses 0xFFF4 in both modes.
- R4: A reset or NMI pulse is held pending until it is serviced and is then cleared. One pulse produces exactly one entry, and an entry for a held request starts on the cycle after the previous entry ends.
- R5: For BRK or COP, the first bus cycle reads the signature byte at `pc_in`, and the stacked program counter is `pc_in+1`. For hardware entries there is no read, and the stacked program counter is `pc_in`.
- R6: The push order is program bank, PC high, PC low, status. The program bank push is omitted in emulation mode. Each push writes at the stack pointer and then decrements it. In emulation mode the pushes use address `{0x01, low byte}` and the low byte wraps within page one.
- R7: In emulation mode the stacked status has bit 4 set for BRK and cleared for every other entry. In native mode the status is stacked unchanged.
- R8: When `load_regs` is high, `pbank_out` is 0 in native mode and equals the latched program bank in emulation mode. `sp_out` is the stack pointer after the pushes.
- R9: When `load_regs` is high, `status_out` is the latched status with bit 2 (interrupt disable) set. An IRQ is ignored while `status_in` bit 2 is 1.
- R10: The vector low byte is read at the vector address and the high byte at the vector address plus 1. `vec_pull` is high in exactly those two cycles. Then `load_regs` is high for one cycle with `pc_out` = {high, low}.
- R11: `busy` is high from the first bus cycle of an entry up to and including the `load_regs` cycle.
- R12: After reset the sequencer is idle, with `busy`, `bus_we`, `bus_rd`, `vec_pull` and `load_regs` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_req | input | 1 | Reset request pulse (latched) |
| nmi_req | input | 1 | NMI request pulse (latched) |
| irq_req | input | 1 | IRQ level request |
| brk_req | input | 1 | BRK opcode decoded |
| cop_req | input | 1 | COP opcode decoded |
| emu_mode | input | 1 | 1 = emulation mode |
| pc_in | input | 16 | Program counter (addresses the signature byte for BRK/COP) |
| pbank_in | input | 8 | Program bank |
| status_in | input | 8 | Status register |
| sp_in | input | 16 | Stack pointer |
| bus_rdata | input | 8 | Read data |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| vec_pull | output | 1 | Vector read cycle |
| busy | output | 1 | Entry in progress |
| pc_out | output | 16 | New program counter |
| pbank_out | output | 8 | New program bank |
| sp_out | output | 16 | New stack pointer |
| status_out | output | 8 | New status |
| load_regs | output | 1 | Core loads the `*_out` values |

## Verification
The in-line assertions check properties that hold on every cycle:
- a read and a write are never issued together;
- `vec_pull` marks only reads, and its two cycles fall on consecutive addresses;
- emulation-mode pushes stay in page one;
- `load_regs` always carries the interrupt-disable bit and is followed by idle.

Only the bench scenarios can show the rest: the priority order among simultaneous requests, the clearing of held requests, the exact frame contents, the break-bit rule, and the vector chosen for each mode and source.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_SIG, ST_PB, ST_PCH, ST_PCL, ST_P, ST_VLO, ST_VHI, ST_JMP
    } step_e;

    typedef enum logic [2:0] {
        K_RESET, K_NMI, K_IRQ, K_BRK, K_COP
    } kind_e;

    localparam int unsigned AW = 16;
    localparam int unsigned DW = 8;

    typedef struct packed {
        step_e           step;
        kind_e           kind;
        logic            emu;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   sp;
        logic [DW-1:0]   pb;
        logic [DW-1:0]   st;
        logic [DW-1:0]   vlo;
        logic [DW-1:0]   vhi;
        logic            pend_rst;
        logic            pend_nmi;
    } seq_s;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_seq_pkg::*;
(
    input  logic  idle,
    input  logic  pend_rst,
    input  logic  pend_nmi,
    input  logic  irq_ok,
    input  logic  brk,
    input  logic  cop,
    output logic  take,
    output kind_e kind
);
    always_comb begin
        take = idle;
        kind = K_COP;
        if (pend_rst)      kind = K_RESET;
        else if (pend_nmi) kind = K_NMI;
        else if (irq_ok)   kind = K_IRQ;
        else if (brk)      kind = K_BRK;
        else if (cop)      kind = K_COP;
        else               take = 1'b0;
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_seq_pkg::*;
#(
    parameter logic [15:0] VEC_RESET  = 16'hFFFC,
    parameter logic [15:0] VEC_NMI    = 16'hFFFA,
    parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
    parameter logic [15:0] VEC_BRK_NV = 16'hFFF6,
    parameter logic [15:0] VEC_COP    = 16'hFFF4
) (
    input  kind_e       kind,
    input  logic        emu,
    output logic [15:0] vec
);
    always_comb begin
        unique case (kind)
            K_RESET: vec = VEC_RESET;
            K_NMI:   vec = VEC_NMI;
            K_IRQ:   vec = VEC_IRQ;
            K_BRK:   vec = emu ? VEC_IRQ : VEC_BRK_NV;
            default: vec = VEC_COP;
        endcase
    end
endmodule

// File: rtl/exc_push_mux.sv
module exc_push_mux
    import exc_seq_pkg::*;
#(
    parameter int unsigned BRK_BIT = 4
) (
    input  step_e       step,
    input  kind_e       kind,
    input  logic        emu,
    input  logic [15:0] pc,
    input  logic [7:0]  pb,
    input  logic [7:0]  st,
    output logic [7:0]  wdata
);
    logic [7:0] st_push;

    always_comb begin
        st_push = st;
        if (emu) st_push[BRK_BIT] = (kind == K_BRK);
        unique case (step)
            ST_PB:   wdata = pb;
            ST_PCH:  wdata = pc[15:8];
            ST_PCL:  wdata = pc[7:0];
            ST_P:    wdata = st_push;
            default: wdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
#(
    parameter int unsigned IRQ_MASK_BIT = 2,
    parameter logic [7:0]  EMU_PAGE     = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reset_req,
    input  logic        nmi_req,
    input  logic        irq_req,
    input  logic        brk_req,
    input  logic        cop_req,
    input  logic        emu_mode,
    input  logic [15:0] pc_in,
    input  logic [7:0]  pbank_in,
    input  logic [7:0]  status_in,
    input  logic [15:0] sp_in,
    input  logic [7:0]  bus_rdata,
    output logic [15:0] bus_addr,
    output logic [7:0]  bus_wdata,
    output logic        bus_we,
    output logic        bus_rd,
    output logic        vec_pull,
    output logic        busy,
    output logic [15:0] pc_out,
    output logic [7:0]  pbank_out,
    output logic [15:0] sp_out,
    output logic [7:0]  status_out,
    output logic        load_regs
);
    seq_s  s_q, s_d;
    logic  take;
    kind_e take_kind;
    logic  eff_rst, eff_nmi;
    logic [15:0] vec;
    logic [7:0]  push_byte;

    assign eff_rst = s_q.pend_rst | reset_req;
    assign eff_nmi = s_q.pend_nmi | nmi_req;

    exc_arbiter u_arb (
        .idle     (s_q.step == ST_IDLE),
        .pend_rst (eff_rst),
        .pend_nmi (eff_nmi),
        .irq_ok   (irq_req & ~status_in[IRQ_MASK_BIT]),
        .brk      (brk_req),
        .cop      (cop_req),
        .take     (take),
        .kind     (take_kind)
    );

    exc_vector u_vec (
        .kind (s_q.kind),
        .emu  (s_q.emu),
        .vec  (vec)
    );

    exc_push_mux u_mux (
        .step  (s_q.step),
        .kind  (s_q.kind),
        .emu   (s_q.emu),
        .pc    (s_q.pc),
        .pb    (s_q.pb),
        .st    (s_q.st),
        .wdata (push_byte)
    );

    function automatic logic [15:0] sp_dec(input logic [15:0] sp, input logic emu);
        return emu ? {EMU_PAGE, sp[7:0] - 8'd1} : sp - 16'd1;
    endfunction

    always_comb begin
        s_d          = s_q;
        s_d.pend_rst = eff_rst;
        s_d.pend_nmi = eff_nmi;
        bus_addr     = 16'h0000;
        bus_wdata    = 8'h00;
        bus_we       = 1'b0;
        bus_rd       = 1'b0;
        vec_pull     = 1'b0;
        load_regs    = 1'b0;
        unique case (s_q.step)
            ST_IDLE: if (take) begin
                s_d.kind = take_kind;
                s_d.emu  = emu_mode;
                s_d.pc   = pc_in;
                s_d.pb   = pbank_in;
                s_d.st   = status_in;
                s_d.sp   = emu_mode ? {EMU_PAGE, sp_in[7:0]} : sp_in;
                if (take_kind == K_RESET) s_d.pend_rst = 1'b0;
                if (take_kind == K_NMI)   s_d.pend_nmi = 1'b0;
                if (take_kind == K_BRK || take_kind == K_COP) s_d.step = ST_SIG;
                else s_d.step = emu_mode ? ST_PCH : ST_PB;
            end
            ST_SIG: begin
                bus_addr = s_q.pc;
                bus_rd   = 1'b1;
                s_d.pc   = s_q.pc + 16'd1;
                s_d.step = s_q.emu ? ST_PCH : ST_PB;
            end
            ST_PB, ST_PCH, ST_PCL, ST_P: begin
                bus_addr  = s_q.sp;
                bus_wdata = push_byte;
                bus_we    = 1'b1;
                s_d.sp    = sp_dec(s_q.sp, s_q.emu);
                unique case (s_q.step)
                    ST_PB:   s_d.step = ST_PCH;
                    ST_PCH:  s_d.step = ST_PCL;
                    ST_PCL:  s_d.step = ST_P;
                    default: s_d.step = ST_VLO;
                endcase
            end
            ST_VLO: begin
                bus_addr = vec;
                bus_rd   = 1'b1;
                vec_pull = 1'b1;
                s_d.vlo  = bus_rdata;
                s_d.step = ST_VHI;
            end
            ST_VHI: begin
                bus_addr = vec + 16'd1;
                bus_rd   = 1'b1;
                vec_pull = 1'b1;
                s_d.vhi  = bus_rdata;
                s_d.step = ST_JMP;
            end
            default: begin
                load_regs = 1'b1;
                s_d.step  = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.step     <= ST_IDLE;
            s_q.kind     <= K_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = (s_q.step != ST_IDLE);
    assign pc_out     = {s_q.vhi, s_q.vlo};
    assign pbank_out  = s_q.emu ? s_q.pb : 8'h00;
    assign sp_out     = s_q.sp;
    assign status_out = s_q.st | (8'h01 << IRQ_MASK_BIT);

    a_r6_rd_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_rd));
    a_r10_vpull_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        vec_pull |-> bus_rd && !bus_we);
    a_r10_vec_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_pull && !load_regs && !$past(vec_pull)) |=>
            (vec_pull && bus_addr == $past(bus_addr) + 16'd1));
    a_r6_emu_page: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && s_q.emu) |-> bus_addr[15:8] == EMU_PAGE);
    a_r11_load_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load_regs |=> !busy);
    a_r11_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        load_regs |-> busy);
    a_r9_iflag_set: assert property (@(posedge clk) disable iff (!rst_n)
        load_regs |-> status_out[IRQ_MASK_BIT]);
    a_r10_load_after_vhi: assert property (@(posedge clk) disable iff (!rst_n)
        load_regs |-> $past(vec_pull));
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reset_req, nmi_req, irq_req, brk_req, cop_req, emu_mode;
    logic [15:0] pc_in, sp_in;
    logic [7:0]  pbank_in, status_in, bus_rdata;
    logic [15:0] bus_addr, pc_out, sp_out;
    logic [7:0]  bus_wdata, pbank_out, status_out;
    logic        bus_we, bus_rd, vec_pull, busy, load_regs;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [25:0] exp_rec [0:7];
    logic [25:0] got_rec [0:15];
    int          exp_n, got_n;
    logic [15:0] exp_pc, exp_sp;
    logic [7:0]  exp_pb, exp_st;
    logic [15:0] g_pc, g_sp;
    logic [7:0]  g_pb, g_st;
    logic        g_load;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .brk_req(brk_req), .cop_req(cop_req),
        .emu_mode(emu_mode), .pc_in(pc_in), .pbank_in(pbank_in),
        .status_in(status_in), .sp_in(sp_in), .bus_rdata(bus_rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rd(bus_rd), .vec_pull(vec_pull), .busy(busy), .pc_out(pc_out),
        .pbank_out(pbank_out), .sp_out(sp_out), .status_out(status_out),
        .load_regs(load_regs)
    );

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    always_comb bus_rdata = mem(bus_addr);

    function automatic logic [15:0] vec_of(input int kind, input logic emu);
        case (kind)
            0: return 16'hFFFC;
            1: return 16'hFFFA;
            2: return 16'hFFFE;
            3: return emu ? 16'hFFFE : 16'hFFF6;
            default: return 16'hFFF4;
        endcase
    endfunction

    function automatic string rname(input int kind, input logic emu);
        case (kind)
            0: return "R2 reset";
            1: return "R2 nmi";
            2: return "R2 irq";
            3: return emu ? "R3/R7 brk emu" : "R3 brk native";
            default: return "R3 cop";
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic build_exp(input int kind, input logic emu, input logic [15:0] pc,
                             input logic [7:0] pb, input logic [7:0] st, input logic [15:0] sp);
        logic [15:0] p, s, v;
        logic [7:0]  stv;
        p = pc; s = emu ? {8'h01, sp[7:0]} : sp; exp_n = 0;
        if (kind >= 3) begin
            exp_rec[exp_n] = {2'b00, p, 8'h00}; exp_n++; p = p + 16'd1;  // R5
        end
        stv = st;
        if (emu) stv[4] = (kind == 3);                                  // R7
        if (!emu) begin
            exp_rec[exp_n] = {2'b01, s, pb}; exp_n++; s = s - 16'd1;     // R6
        end
        exp_rec[exp_n] = {2'b01, s, p[15:8]}; exp_n++;
        s = emu ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
        exp_rec[exp_n] = {2'b01, s, p[7:0]}; exp_n++;
        s = emu ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
        exp_rec[exp_n] = {2'b01, s, stv}; exp_n++;
        s = emu ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
        v = vec_of(kind, emu);
        exp_rec[exp_n] = {2'b10, v, 8'h00}; exp_n++;
        exp_rec[exp_n] = {2'b10, v + 16'd1, 8'h00}; exp_n++;
        exp_pc = {mem(v + 16'd1), mem(v)};
        exp_sp = s;
        exp_pb = emu ? pb : 8'h00;
        exp_st = st | 8'h04;
    endtask

    task automatic observe();
        int guard = 0;
        got_n = 0; g_load = 1'b0;
        while (busy && guard < 20) begin
            if (bus_we || bus_rd) begin
                if (got_n < 16) got_rec[got_n] = {vec_pull, bus_we, bus_addr, bus_we ? bus_wdata : 8'h00};
                got_n++;
            end
            if (load_regs) begin
                g_load = 1'b1; g_pc = pc_out; g_sp = sp_out; g_pb = pbank_out; g_st = status_out;
            end
            guard++;
            @(negedge clk);
        end
    endtask

    task automatic compare(input string req);
        logic ok = (got_n == exp_n);
        for (int i = 0; i < exp_n && ok; i++) if (got_rec[i] !== exp_rec[i]) ok = 1'b0;
        check({req, " R6/R10 bus sequence length"}, 64'(got_n), 64'(exp_n));
        checks++;
        if (!ok) begin
            errors++;
            for (int i = 0; i < exp_n && i < got_n; i++)
                if (got_rec[i] !== exp_rec[i])
                    $display("FAIL %s R5/R6/R10 cycle %0d: actual %0h expected %0h", req, i, got_rec[i], exp_rec[i]);
            if (got_n != exp_n) $display("FAIL %s R6 count: actual %0d expected %0d", req, got_n, exp_n);
        end
        check({req, " R10/R11 load seen"}, 64'(g_load), 64'd1);
        check({req, " R10 pc_out"}, 64'(g_pc), 64'(exp_pc));
        check({req, " R8 sp_out"}, 64'(g_sp), 64'(exp_sp));
        check({req, " R8 pbank_out"}, 64'(g_pb), 64'(exp_pb));
        check({req, " R9 status_out"}, 64'(g_st), 64'(exp_st));
    endtask

    task automatic entry(input int kind, input logic emu, input logic [15:0] pc,
                         input logic [7:0] pb, input logic [7:0] st, input logic [15:0] sp);
        emu_mode = emu; pc_in = pc; pbank_in = pb; status_in = st; sp_in = sp;
        reset_req = (kind == 0); nmi_req = (kind == 1); irq_req = (kind == 2);
        brk_req = (kind == 3); cop_req = (kind == 4);
        @(negedge clk);
        reset_req = 0; nmi_req = 0; irq_req = 0; brk_req = 0; cop_req = 0;
        build_exp(kind, emu, pc, pb, st, sp);
        observe();
        compare(rname(kind, emu));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seen;
        void'($urandom(32'd1234));
        rst_n = 0; reset_req = 0; nmi_req = 0; irq_req = 0; brk_req = 0; cop_req = 0;
        emu_mode = 0; pc_in = 0; pbank_in = 0; status_in = 0; sp_in = 16'h01FF;
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 idle after reset", {59'd0, busy, bus_we, bus_rd, vec_pull, load_regs}, 64'd0);
        rst_n = 1;
        @(negedge clk);

        // Directed cases: each source in both modes
        entry(1, 1'b1, 16'h1234, 8'h7E, 8'h30, 16'h01FF);
        entry(2, 1'b0, 16'hABCD, 8'h12, 8'h21, 16'h0400);
        entry(3, 1'b1, 16'h2000, 8'h00, 8'h20, 16'h0102);   // R6 page-one wrap
        entry(3, 1'b0, 16'h2FFF, 8'h55, 8'h10, 16'h8000);
        entry(4, 1'b1, 16'h4000, 8'h33, 8'h00, 16'h01F0);
        entry(4, 1'b0, 16'h5000, 8'h44, 8'hC3, 16'h2000);
        entry(0, 1'b0, 16'h0000, 8'h09, 8'h00, 16'h0100);

        // R9: masked IRQ ignored
        status_in = 8'h04; irq_req = 1; seen = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); if (busy) seen++; end
        irq_req = 0;
        check("R9 masked irq ignored", 64'(seen), 64'd0);

        // R1/R4: reset, NMI and IRQ together; then NMI held; then nothing
        emu_mode = 0; pc_in = 16'h0800; pbank_in = 8'h02; status_in = 8'h00; sp_in = 16'h0300;
        reset_req = 1; nmi_req = 1; irq_req = 1; brk_req = 1;
        @(negedge clk);
        reset_req = 0; nmi_req = 0; irq_req = 0; brk_req = 0;
        build_exp(0, 1'b0, 16'h0800, 8'h02, 8'h00, 16'h0300);
        observe(); compare("R1 priority reset first");
        @(negedge clk);
        build_exp(1, 1'b0, 16'h0800, 8'h02, 8'h00, 16'h0300);
        observe(); compare("R1/R4 held nmi next");
        seen = 0;
        for (int i = 0; i < 4; i++) begin @(negedge clk); if (busy) seen++; end
        check("R4 nmi cleared after service", 64'(seen), 64'd0);

        // R1: BRK over COP
        brk_req = 1; cop_req = 1; emu_mode = 0; pc_in = 16'h0900;
        @(negedge clk);
        brk_req = 0; cop_req = 0;
        build_exp(3, 1'b0, 16'h0900, 8'h02, 8'h00, 16'h0300);
        observe(); compare("R1 brk over cop");

        // Random entries
        for (int n = 0; n < 40; n++) begin
            int k = int'($urandom_range(0, 4));
            logic [7:0] st = 8'($urandom);
            if (k == 2) st[2] = 1'b0;
            entry(k, 1'($urandom), 16'($urandom), 8'($urandom), st, 16'($urandom));
            @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule